// File: doc/BRIEF.md
# AHB-Lite timer register slave

This block is the bus front end of a tick timer. It sits on an AHB-Lite bus as a slave and turns each accepted transfer into either a read of one register word or a one-cycle write strobe toward the timer's register bank. The prescaler, enable mask, 64-bit time counter and per-channel compare values live outside this block. It only decodes addresses, times the strobes and multiplexes read data.

The address phase is registered when the bus is ready. The write strobe and the read data then follow in the next cycle, the data phase. The slave never stretches a transfer and never signals an error. The data bus is 32 or 64 bits wide, set by a parameter. On a 32-bit bus each 64-bit register is reached as two word addresses, low word first. On a 64-bit bus a doubleword transfer reaches both halves at once.

The register bank takes its write data from a 64-bit write-data output. A word with an even word index (byte offset bit 2 clear) takes bits 31:0, and a word with an odd index takes bits 63:32. On a 32-bit bus the bus word is copied into both lanes.

Top module: `tmr_ahb_regif`

## Requirements
- R1: `hreadyout` is 1 and `hresp` is 0 (OKAY) in every cycle, including during and after reset.
- R2: A transfer is accepted only when `hsel` is 1, `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and `hready` is 1 in its address phase. An unselected bus, IDLE (2'b00) or BUSY (2'b01) produces no write strobe and leaves every register word unchanged.
- R3: The write strobe of an accepted write is high for exactly the one data-phase cycle that follows the address phase, and is low during the address phase itself. The data goes out on `wr_data_o`: bits 31:0 for an even word index and bits 63:32 for an odd one. On a 32-bit bus `hwdata` is copied into both halves.
- R4: The word index is `haddr[MAP_W-1:2]`, and address bits at or above `MAP_W` are ignored. The word map is as follows:
  - 0: prescaler
  - 1: reserved
  - 2: pending (read only)
  - 3: enable
  - 4 and 5: time, low then high
  - 6+2n and 7+2n: compare n, low then high
  
  Bit 2n of `wr_cmp_o` strobes the low word of compare n, and bit 2n+1 strobes the high word. Bit 0 of `wr_time_o` strobes the low word of time, and bit 1 strobes the high word.
- R5: On a 64-bit bus, a write with `hsize` 3'b011 strobes both writable words of the addressed doubleword. A smaller size strobes only the word picked by `haddr[2]`. On a 32-bit bus exactly the addressed word is strobed, whatever the size.
- R6: On a 32-bit bus, `hrdata` in the data phase carries the addressed word. On a 64-bit bus it carries the doubleword, with the odd word in bits 63:32 and the even word in bits 31:0.
- R7: The pending and enable words read back only their low `NT` bits, and their upper bits read 0.
- R8: A write to the pending word, the reserved word or any word index at or beyond 6+2*NT produces no strobe. A read of the reserved word or of an index beyond the map returns 0.
- R9: `hresetn` low clears the captured address phase at once, without waiting for a clock edge. While it is low no write strobe is driven, even for a transfer already in flight.
- R10: While `hready` is 0 the address-phase inputs are not sampled, so a request presented with `hready` 0 is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Bus clock, rising edge |
| hresetn | input | 1 | Asynchronous reset, active low |
| hsel | input | 1 | Slave select |
| htrans | input | 2 | Transfer type |
| haddr | input | AW | Byte address |
| hwrite | input | 1 | 1 for write, 0 for read |
| hsize | input | 3 | Transfer size code |
| hwdata | input | DW | Write data (data phase) |
| hready | input | 1 | Bus ready, previous transfer complete |
| hrdata | output | DW | Read data (data phase) |
| hreadyout | output | 1 | Always ready |
| hresp | output | 1 | Always OKAY |
| prescale_i | input | 32 | Current prescaler word |
| pending_i | input | NT | Pending flags, one per channel |
| enable_i | input | NT | Interrupt enable flags |
| time_i | input | 64 | Current time count |
| cmp_i | input | 64*NT | Compare values, channel n at bits 64n+63:64n |
| wr_data_o | output | 64 | Write data, even-word lane low, odd-word lane high |
| wr_prescale_o | output | 1 | Prescaler write strobe |
| wr_enable_o | output | 1 | Enable write strobe |
| wr_time_o | output | 2 | Time word strobes, bit 0 low word |
| wr_cmp_o | output | 2*NT | Compare word strobes, bit 2n low word of channel n |

## Verification
The bench builds two copies with two channels, a 12-bit address and a 6-bit decoded window: one with a 32-bit bus and one with a 64-bit bus. Both share the same bus stimulus. This small map has ten words inside a sixteen-word window. A sweep over every word index can therefore hit each mapped register, the reserved and read-only words, and six unmapped indices. A high-bit alias exercises the ignored upper address bits. Doubleword writes on the wide copy show the pairing, including pairs with only one writable half.

// File: rtl/tmr_ahb_pkg.sv
package tmr_ahb_pkg;
   // word indices inside the decoded window
   localparam int unsigned WI_PRESC = 0;
   localparam int unsigned WI_PEND  = 2;
   localparam int unsigned WI_EN    = 3;
   localparam int unsigned WI_TIME  = 4;
   localparam int unsigned WI_CMP   = 6;

   localparam logic [1:0] TR_NSEQ  = 2'b10;
   localparam logic [1:0] TR_SEQ   = 2'b11;
   localparam logic [2:0] SZ_DWORD = 3'b011;

   // number of 32-bit words spanned by the map for nt channels
   function automatic int unsigned map_words(input int unsigned nt);
      return WI_CMP + 2 * nt;
   endfunction
endpackage

// File: rtl/tmr_ahb_aphase.sv
module tmr_ahb_aphase #(
   parameter int IW = 4
) (
   input  logic          hclk,
   input  logic          hresetn,
   input  logic          hsel,
   input  logic [1:0]    htrans,
   input  logic          hready,
   input  logic          hwrite,
   input  logic [2:0]    hsize,
   input  logic [IW-1:0] widx,
   output logic          dph_vld,
   output logic          dph_wr,
   output logic          dph_dw,
   output logic [IW-1:0] dph_idx
);
   import tmr_ahb_pkg::*;

   logic req;
   assign req = hsel && ((htrans == TR_NSEQ) || (htrans == TR_SEQ));

   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         dph_vld <= 1'b0;
         dph_wr  <= 1'b0;
         dph_dw  <= 1'b0;
         dph_idx <= '0;
      end else if (hready) begin
         dph_vld <= req;
         dph_wr  <= hwrite;
         dph_dw  <= (hsize == SZ_DWORD);
         dph_idx <= widx;
      end
   end
endmodule

// File: rtl/tmr_ahb_wdec.sv
module tmr_ahb_wdec #(
   parameter int NT = 3,
   parameter int DW = 32,
   parameter int IW = 8
) (
   input  logic          vld,
   input  logic          wr,
   input  logic          dw,
   input  logic          rdy,
   input  logic [IW-1:0] idx,
   output logic          we_presc,
   output logic          we_en,
   output logic [1:0]    we_time,
   output logic [2*NT-1:0] we_cmp
);
   import tmr_ahb_pkg::*;

   // strobe for word k: direct word hit, or doubleword pair hit on a wide bus
   function automatic logic hit(input int unsigned k);
      logic go;
      logic word;
      logic pair;
      go   = vld && wr && rdy;
      word = (idx == IW'(k));
      pair = (DW == 64) && dw && (idx[IW-1:1] == (IW-1)'(k >> 1));
      return go && (word || pair);
   endfunction

   assign we_presc   = hit(WI_PRESC);
   assign we_en      = hit(WI_EN);
   assign we_time[0] = hit(WI_TIME);
   assign we_time[1] = hit(WI_TIME + 1);

   for (genvar n = 0; n < NT; n++) begin : g_cmp
      assign we_cmp[2*n]   = hit(WI_CMP + 2*n);
      assign we_cmp[2*n+1] = hit(WI_CMP + 2*n + 1);
   end
endmodule

// File: rtl/tmr_ahb_rmux.sv
module tmr_ahb_rmux #(
   parameter int NT = 3,
   parameter int DW = 32,
   parameter int IW = 8
) (
   input  logic [IW-1:0]    idx,
   input  logic [31:0]      presc,
   input  logic [NT-1:0]    pend,
   input  logic [NT-1:0]    en,
   input  logic [63:0]      tval,
   input  logic [64*NT-1:0] cmp,
   output logic [DW-1:0]    rdata
);
   import tmr_ahb_pkg::*;

   localparam int NW = map_words(NT);

   logic [31:0] words [NW];

   always_comb begin
      words[WI_PRESC] = presc;
      words[1]        = '0;
      words[WI_PEND]  = 32'(pend);
      words[WI_EN]    = 32'(en);
      words[WI_TIME]  = tval[31:0];
      words[WI_TIME+1] = tval[63:32];
      for (int n = 0; n < NT; n++) begin
         words[WI_CMP + 2*n]     = cmp[64*n +: 32];
         words[WI_CMP + 2*n + 1] = cmp[64*n + 32 +: 32];
      end
   end

   if (DW == 32) begin : g_word
      always_comb begin
         rdata = '0;
         for (int k = 0; k < NW; k++)
            if (idx == IW'(k)) rdata = words[k];
      end
   end else begin : g_dword
      logic unused_lsb;
      assign unused_lsb = idx[0];
      always_comb begin
         rdata = '0;
         for (int k = 0; k < NW/2; k++)
            if (idx[IW-1:1] == (IW-1)'(k)) rdata = {words[2*k+1], words[2*k]};
      end
   end
endmodule

// File: rtl/tmr_ahb_regif.sv
module tmr_ahb_regif #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int NT    = 3,
   parameter int MAP_W = 10
) (
   input  logic             hclk,
   input  logic             hresetn,
   input  logic             hsel,
   input  logic [1:0]       htrans,
   input  logic [AW-1:0]    haddr,
   input  logic             hwrite,
   input  logic [2:0]       hsize,
   input  logic [DW-1:0]    hwdata,
   input  logic             hready,
   output logic [DW-1:0]    hrdata,
   output logic             hreadyout,
   output logic             hresp,
   input  logic [31:0]      prescale_i,
   input  logic [NT-1:0]    pending_i,
   input  logic [NT-1:0]    enable_i,
   input  logic [63:0]      time_i,
   input  logic [64*NT-1:0] cmp_i,
   output logic [63:0]      wr_data_o,
   output logic             wr_prescale_o,
   output logic             wr_enable_o,
   output logic [1:0]       wr_time_o,
   output logic [2*NT-1:0]  wr_cmp_o
);
   import tmr_ahb_pkg::*;

   localparam int IW = MAP_W - 2;
   localparam int NW = map_words(NT);

   // elaboration-time parameter checks
   if (DW != 32 && DW != 64) begin : g_bad_dw
      $error("tmr_ahb_regif: DW must be 32 or 64");
   end
   if (NT < 1 || NT > 32) begin : g_bad_nt
      $error("tmr_ahb_regif: NT must lie in 1..32");
   end
   if (MAP_W >= AW || (NW * 4) > (1 << MAP_W)) begin : g_bad_map
      $error("tmr_ahb_regif: MAP_W too small for the map or not below AW");
   end

   logic          dph_vld;
   logic          dph_wr;
   logic          dph_dw;
   logic [IW-1:0] dph_idx;
   logic          unused_addr;

   assign unused_addr = ^{haddr[AW-1:MAP_W], haddr[1:0]};
   assign hreadyout   = 1'b1;
   assign hresp       = 1'b0;

   tmr_ahb_aphase #(.IW(IW)) u_aphase (
      .hclk    (hclk),
      .hresetn (hresetn),
      .hsel    (hsel),
      .htrans  (htrans),
      .hready  (hready),
      .hwrite  (hwrite),
      .hsize   (hsize),
      .widx    (haddr[MAP_W-1:2]),
      .dph_vld (dph_vld),
      .dph_wr  (dph_wr),
      .dph_dw  (dph_dw),
      .dph_idx (dph_idx)
   );

   tmr_ahb_wdec #(.NT(NT), .DW(DW), .IW(IW)) u_wdec (
      .vld      (dph_vld),
      .wr       (dph_wr),
      .dw       (dph_dw),
      .rdy      (hready),
      .idx      (dph_idx),
      .we_presc (wr_prescale_o),
      .we_en    (wr_enable_o),
      .we_time  (wr_time_o),
      .we_cmp   (wr_cmp_o)
   );

   tmr_ahb_rmux #(.NT(NT), .DW(DW), .IW(IW)) u_rmux (
      .idx   (dph_idx),
      .presc (prescale_i),
      .pend  (pending_i),
      .en    (enable_i),
      .tval  (time_i),
      .cmp   (cmp_i),
      .rdata (hrdata)
   );

   if (DW == 64) begin : g_wd64
      assign wr_data_o = hwdata;
   end else begin : g_wd32
      assign wr_data_o = {hwdata, hwdata};
   end
endmodule

// File: rtl/tmr_ahb_regif_chk.sv
module tmr_ahb_regif_chk #(
   parameter int DW    = 32,
   parameter int NT    = 3,
   parameter int MAP_W = 10
) (
   input logic              hclk,
   input logic              hresetn,
   input logic              hsel,
   input logic [1:0]        htrans,
   input logic              hwrite,
   input logic              hready,
   input logic [MAP_W-3:0]  aidx,
   input logic [DW-1:0]     hrdata,
   input logic [3+2*NT:0]   we
);
   localparam int IW  = MAP_W - 2;
   localparam int NW  = 6 + 2 * NT;
   localparam int LIM = (DW == 64) ? 2 : 1;

   logic any_we;
   logic req;
   logic unmapped;
   assign any_we   = |we;
   assign req      = hsel && htrans[1];
   assign unmapped = ({1'b0, aidx} >= (IW+1)'(NW));

   // R2: a strobe needs an accepted write in the cycle before
   p_wr_from_req_r2: assert property (@(posedge hclk) disable iff (!hresetn)
      any_we |-> $past(req && hready && hwrite));

   // R2: idle, busy or unselected address phase gives no strobe next cycle
   p_idle_quiet_r2: assert property (@(posedge hclk) disable iff (!hresetn)
      $past(hready && !req) |-> !any_we);

   // R5: at most one word strobe (two on a wide bus) at a time
   p_strobe_count_r5: assert property (@(posedge hclk) disable iff (!hresetn)
      $countones(we) <= LIM);

   // R8: reads beyond the map return zero
   p_unmapped_zero_r8: assert property (@(posedge hclk) disable iff (!hresetn)
      $past(hready && req && !hwrite && unmapped) |-> (hrdata == '0));

   // R9: no strobe while reset is held
   p_rst_quiet_r9: assert property (@(posedge hclk)
      !hresetn |-> !any_we);
endmodule

bind tmr_ahb_regif tmr_ahb_regif_chk #(.DW(DW), .NT(NT), .MAP_W(MAP_W)) u_chk (
   .hclk    (hclk),
   .hresetn (hresetn),
   .hsel    (hsel),
   .htrans  (htrans),
   .hwrite  (hwrite),
   .hready  (hready),
   .aidx    (haddr[MAP_W-1:2]),
   .hrdata  (hrdata),
   .we      ({wr_prescale_o, wr_enable_o, wr_time_o, wr_cmp_o})
);

// File: tb/tmr_ahb_regif_bench.sv
module tmr_ahb_regif_bank #(
   parameter int NT = 2
) (
   input  logic             hclk,
   input  logic             hresetn,
   input  logic [63:0]      wd,
   input  logic             we_p,
   input  logic             we_e,
   input  logic [1:0]       we_t,
   input  logic [2*NT-1:0]  we_c,
   output logic [31:0]      presc,
   output logic [NT-1:0]    en,
   output logic [63:0]      tv,
   output logic [64*NT-1:0] cmp
);
   always_ff @(posedge hclk or negedge hresetn) begin
      if (!hresetn) begin
         presc <= '0; en <= '0; tv <= '0; cmp <= '0;
      end else begin
         if (we_p)    presc       <= wd[31:0];
         if (we_e)    en          <= wd[32 +: NT];
         if (we_t[0]) tv[31:0]    <= wd[31:0];
         if (we_t[1]) tv[63:32]   <= wd[63:32];
         for (int n = 0; n < NT; n++) begin
            if (we_c[2*n])   cmp[64*n +: 32]      <= wd[31:0];
            if (we_c[2*n+1]) cmp[64*n + 32 +: 32] <= wd[63:32];
         end
      end
   end
endmodule

module tmr_ahb_regif_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NT    = 2;
   localparam int AW    = 12;
   localparam int MAP_W = 6;
   localparam int NW    = 6 + 2 * NT;
   localparam logic [NT-1:0] PEND = 2'b10;

   logic hclk = 1'b0;
   logic hresetn;
   logic hsel, hwrite, hready;
   logic [1:0] htrans;
   logic [AW-1:0] haddr;
   logic [2:0] hsize;
   logic [31:0] hwdata_n;
   logic [63:0] hwdata_w;

   logic [31:0] hrdata_n;
   logic [63:0] hrdata_w;
   logic hro_n, hro_w, hrs_n, hrs_w;

   logic [63:0] wd_n, wd_w;
   logic wp_n, we_n_e, wp_w, we_w_e;
   logic [1:0] wt_n, wt_w;
   logic [2*NT-1:0] wc_n, wc_w;
   logic [31:0] presc_n, presc_w;
   logic [NT-1:0] en_n, en_w;
   logic [63:0] tv_n, tv_w;
   logic [64*NT-1:0] cmp_n, cmp_w;

   always #(CLK_PERIOD/2) hclk = ~hclk;

   tmr_ahb_regif #(.AW(AW), .DW(32), .NT(NT), .MAP_W(MAP_W)) u_tmr_ahb_regif (
      .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .haddr(haddr),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata_n), .hready(hready),
      .hrdata(hrdata_n), .hreadyout(hro_n), .hresp(hrs_n),
      .prescale_i(presc_n), .pending_i(PEND), .enable_i(en_n), .time_i(tv_n), .cmp_i(cmp_n),
      .wr_data_o(wd_n), .wr_prescale_o(wp_n), .wr_enable_o(we_n_e), .wr_time_o(wt_n), .wr_cmp_o(wc_n)
   );

   tmr_ahb_regif #(.AW(AW), .DW(64), .NT(NT), .MAP_W(MAP_W)) u_tmr_ahb_regif_w (
      .hclk(hclk), .hresetn(hresetn), .hsel(hsel), .htrans(htrans), .haddr(haddr),
      .hwrite(hwrite), .hsize(hsize), .hwdata(hwdata_w), .hready(hready),
      .hrdata(hrdata_w), .hreadyout(hro_w), .hresp(hrs_w),
      .prescale_i(presc_w), .pending_i(PEND), .enable_i(en_w), .time_i(tv_w), .cmp_i(cmp_w),
      .wr_data_o(wd_w), .wr_prescale_o(wp_w), .wr_enable_o(we_w_e), .wr_time_o(wt_w), .wr_cmp_o(wc_w)
   );

   tmr_ahb_regif_bank #(.NT(NT)) u_bank_n (
      .hclk(hclk), .hresetn(hresetn), .wd(wd_n), .we_p(wp_n), .we_e(we_n_e), .we_t(wt_n),
      .we_c(wc_n), .presc(presc_n), .en(en_n), .tv(tv_n), .cmp(cmp_n));
   tmr_ahb_regif_bank #(.NT(NT)) u_bank_w (
      .hclk(hclk), .hresetn(hresetn), .wd(wd_w), .we_p(wp_w), .we_e(we_w_e), .we_t(wt_w),
      .we_c(wc_w), .presc(presc_w), .en(en_w), .tv(tv_w), .cmp(cmp_w));

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] exp_n [NW];
   logic [31:0] exp_w [NW];
   logic [31:0] rd_n;
   logic [63:0] rd_w;
   int wec_n, wec_w, aph_n, aph_w;

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] wmask(input int k);
      if (k == 0) return '1;
      if (k == 3) return 32'((1 << NT) - 1);
      if (k >= 4 && k < NW) return '1;
      return '0;
   endfunction

   function automatic logic [31:0] ew_n(input int k);
      if (k >= NW) return '0;
      if (k == 2) return 32'(PEND);
      return exp_n[k];
   endfunction

   function automatic logic [31:0] ew_w(input int k);
      if (k >= NW) return '0;
      if (k == 2) return 32'(PEND);
      return exp_w[k];
   endfunction

   function automatic logic [63:0] pat(input int k);
      return (64'h1111_1111_1111_1111 * 64'(k + 1)) ^ 64'hF0F0_0F0F_55AA_33CC;
   endfunction

   function automatic int wr_cnt(input int k);
      return (k < NW && wmask(k) != 0) ? 1 : 0;
   endfunction

   task automatic model_wr(input logic [AW-1:0] a, input logic [2:0] sz, input logic [63:0] d);
      int k;
      logic [31:0] v;
      k = int'(a[MAP_W-1:2]);
      v = a[2] ? d[63:32] : d[31:0];
      if (k < NW) exp_n[k] = (exp_n[k] & ~wmask(k)) | (v & wmask(k));
      if (sz == 3'b011) begin
         int lo;
         lo = k & ~1;
         if (lo < NW) begin
            exp_w[lo]   = (exp_w[lo]   & ~wmask(lo))   | (d[31:0]  & wmask(lo));
            exp_w[lo+1] = (exp_w[lo+1] & ~wmask(lo+1)) | (d[63:32] & wmask(lo+1));
         end
      end else if (k < NW) begin
         exp_w[k] = (exp_w[k] & ~wmask(k)) | (v & wmask(k));
      end
   endtask

   task automatic xfer(input logic sel, input logic [1:0] tr, input logic rdy, input logic wr,
                       input logic [AW-1:0] a, input logic [2:0] sz, input logic [63:0] d);
      @(negedge hclk);
      hsel = sel; htrans = tr; hready = rdy; hwrite = wr; haddr = a; hsize = sz;
      #1;
      aph_n = $countones({wp_n, we_n_e, wt_n, wc_n});
      aph_w = $countones({wp_w, we_w_e, wt_w, wc_w});
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00; hready = 1'b1;
      hwdata_w = d;
      hwdata_n = a[2] ? d[63:32] : d[31:0];
      #1;
      rd_n  = hrdata_n;
      rd_w  = hrdata_w;
      wec_n = $countones({wp_n, we_n_e, wt_n, wc_n});
      wec_w = $countones({wp_w, we_w_e, wt_w, wc_w});
      chk("R1 ready/okay", {60'd0, hro_n, hro_w, hrs_n, hrs_w}, 64'b1100);
      chk("R3 no strobe in address phase", 64'(aph_n + aph_w), 64'd0);
      if (sel && tr[1] && rdy && wr) model_wr(a, sz, d);
   endtask

   task automatic read_sweep(input string tag);
      for (int k = 0; k < 16; k++) begin
         xfer(1'b1, 2'b10, 1'b1, 1'b0, AW'(k * 4), 3'b010, 64'd0);
         if (k == 2 || k == 3)
            chk({tag, " R7 narrow masked word"}, 64'(rd_n), 64'(ew_n(k)));
         else if (k == 1 || k >= NW)
            chk({tag, " R8 narrow unmapped"}, 64'(rd_n), 64'(ew_n(k)));
         else
            chk({tag, " R4 narrow word"}, 64'(rd_n), 64'(ew_n(k)));
         chk({tag, " R6 wide dword"}, rd_w, {ew_w(k | 1), ew_w(k & ~1)});
      end
   endtask

   initial begin
      hresetn = 1'b0; hsel = 1'b0; htrans = 2'b00; hready = 1'b1; hwrite = 1'b0;
      haddr = '0; hsize = 3'b010; hwdata_n = '0; hwdata_w = '0;
      for (int k = 0; k < NW; k++) begin exp_n[k] = '0; exp_w[k] = '0; end
      repeat (3) @(posedge hclk);
      #1;
      chk("R1 reset ready/okay", {60'd0, hro_n, hro_w, hrs_n, hrs_w}, 64'b1100);
      chk("R9 reset strobes", 64'({wp_n, we_n_e, wt_n, wc_n, wp_w, we_w_e, wt_w, wc_w}), 64'd0);
      @(negedge hclk);
      hresetn = 1'b1;

      // word writes over the whole window, NONSEQ and SEQ alternating
      for (int k = 0; k < 16; k++) begin
         xfer(1'b1, (k % 2) ? 2'b11 : 2'b10, 1'b1, 1'b1, AW'(k * 4), 3'b010, pat(k));
         chk("R3 narrow strobe in data phase", 64'(wec_n), 64'(wr_cnt(k)));
         chk("R5 wide word strobe", 64'(wec_w), 64'(wr_cnt(k)));
      end
      read_sweep("word");

      // doubleword writes
      for (int p = 0; p < 8; p++) begin
         xfer(1'b1, 2'b10, 1'b1, 1'b1, AW'(p * 8), 3'b011, ~pat(p + 20));
         chk("R5 narrow ignores size", 64'(wec_n), 64'(wr_cnt(2*p)));
         chk("R5 wide dword strobes", 64'(wec_w), 64'(wr_cnt(2*p) + wr_cnt(2*p + 1)));
      end
      read_sweep("dword");

      // transfers that must be ignored
      xfer(1'b0, 2'b10, 1'b1, 1'b1, AW'(0), 3'b010, 64'hDEAD_0001);
      chk("R2 unselected no strobe", 64'(wec_n + wec_w), 64'd0);
      xfer(1'b1, 2'b00, 1'b1, 1'b1, AW'(0), 3'b010, 64'hDEAD_0002);
      chk("R2 IDLE no strobe", 64'(wec_n + wec_w), 64'd0);
      xfer(1'b1, 2'b01, 1'b1, 1'b1, AW'(0), 3'b010, 64'hDEAD_0003);
      chk("R2 BUSY no strobe", 64'(wec_n + wec_w), 64'd0);
      xfer(1'b1, 2'b10, 1'b0, 1'b1, AW'(0), 3'b010, 64'hDEAD_0004);
      chk("R10 hready low no strobe", 64'(wec_n + wec_w), 64'd0);
      xfer(1'b1, 2'b10, 1'b1, 1'b0, AW'(0), 3'b010, 64'd0);
      chk("R2 prescaler unchanged narrow", 64'(rd_n), 64'(ew_n(0)));
      chk("R10 prescaler unchanged wide", rd_w, {ew_w(1), ew_w(0)});

      // upper address bits alias into the window
      xfer(1'b1, 2'b10, 1'b1, 1'b1, AW'(12'hFC0 | 12'h00C), 3'b010, 64'h0000_0001_0000_0000);
      chk("R4 alias strobe", 64'(wec_n), 64'd1);
      xfer(1'b1, 2'b10, 1'b1, 1'b0, AW'(12'h00C), 3'b010, 64'd0);
      chk("R4 alias enable readback", 64'(rd_n), 64'(ew_n(3)));
      chk("R7 enable upper bits", 64'(rd_n), 64'h1);

      // reset while a write is in flight
      @(negedge hclk);
      hsel = 1'b1; htrans = 2'b10; hwrite = 1'b1; haddr = '0; hsize = 3'b010;
      @(negedge hclk);
      hsel = 1'b0; htrans = 2'b00; hwdata_n = 32'h5555_AAAA; hwdata_w = 64'h5555_AAAA;
      hresetn = 1'b0;
      #1;
      chk("R9 in-flight write dropped", 64'({wp_n, we_n_e, wt_n, wc_n, wp_w, we_w_e, wt_w, wc_w}), 64'd0);
      for (int k = 0; k < NW; k++) begin exp_n[k] = '0; exp_w[k] = '0; end
      @(negedge hclk);
      hresetn = 1'b1;
      xfer(1'b1, 2'b10, 1'b1, 1'b0, AW'(0), 3'b010, 64'd0);
      chk("R9 prescaler after reset", 64'(rd_n), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge hclk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule